// File: doc/BRIEF.md
# Program/Erase Status Poll Unit

This block sits between the array read port of a self-timed flash device and the host read data path. It owns the internal busy timer: a program request runs the timer for a fixed number of clocks, an erase request for a longer fixed number. No external timing input is needed. While the timer runs, reads do not return plain array contents. Two bit positions carry completion status instead.

The first status bit is a data-polling flag. During a program it shows the inverse of the same bit of the byte that was loaded for programming. During an erase it reads 0, which is the inverse of the erased value 1. The second status bit is a toggle that flips on every read accepted while the operation is busy, and it starts from 0 at each new operation. Software can poll either bit at any time during the busy period. Once the timer expires, every bit of every read is true array data, and the toggle stops moving.

An asynchronous reset aborts any operation in progress at once. The interrupted program or erase must then be issued again and runs its full duration. The bit positions of both flags, the data width and both durations are parameters.

Top module: `pollst_unit`

## Requirements
- R1: While reset is asserted, `busy` is 0 and `rd_data` is all zeros.
- R2: A `start_prog` pulse accepted while idle raises `busy` at the next clock edge and keeps it high for exactly PROG_CYCLES clock cycles.
- R3: A `start_erase` pulse accepted while idle keeps `busy` high for exactly ERASE_CYCLES cycles. If both start inputs are high in the same idle cycle, the erase is taken.
- R4: Start requests made while `busy` is high are ignored: the busy duration, the operation kind and the latched program byte do not change.
- R5: A read accepted during a program returns, at bit FLAG_BIT (default 7), the inverse of that bit of the byte on `load_data` when the program was accepted.
- R6: A read accepted during an erase returns 0 at bit FLAG_BIT.
- R7: At bit TOG_BIT (default 6), the first read accepted in an operation returns 0, and each further read accepted while busy returns the inverse of the previous one. Reads need not be in adjacent cycles.
- R8: Bits other than FLAG_BIT and TOG_BIT always pass `array_data`. When idle, all bits pass `array_data`, and repeated idle reads leave bit TOG_BIT equal to array data.
- R9: Asserting reset during an operation drops `busy` immediately. After reset is released, reads return array data, and a new program runs its full PROG_CYCLES.
- R10: `rd_data` is updated one clock after a cycle with `rd_en` high and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts the current operation |
| start_prog | input | 1 | Request a program operation (one-cycle pulse) |
| start_erase | input | 1 | Request an erase operation (one-cycle pulse) |
| load_data | input | DW | Byte being programmed, captured with an accepted `start_prog` |
| rd_en | input | 1 | Read strobe |
| array_data | input | DW | Data read from the array in the strobe cycle |
| rd_data | output | DW | Registered read data, with status substituted while busy |
| busy | output | 1 | Program or erase in progress |

## Verification
The bound checker watches the following on every clock:
- `busy` rises only after a start request, and a busy period never lasts longer than the longer of the two durations.
- An idle read returns array data unchanged.
- The polling flag is correct for the current operation kind.
- Back-to-back busy reads flip the toggle bit.
- `rd_data` holds between reads.
- Start requests made while busy leave the latched byte alone.

Some behaviours are shown only by the bench's scenarios:
- The exact busy lengths for program and for erase.
- Erase taking priority over program when both are requested together.
- The toggle being cleared at a new operation after an odd number of reads in the previous one.
- The toggle continuing across reads that are not in adjacent cycles.
- The effect of reset on an operation in progress, followed by a full-length restart.

// File: rtl/pollst_pkg.sv
package pollst_pkg;

   typedef enum logic [1:0] {
      OPK_IDLE  = 2'd0,
      OPK_PROG  = 2'd1,
      OPK_ERASE = 2'd2
   } opk_t;

   function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pollst_timer.sv
module pollst_timer
   import pollst_pkg::*;
#(
   parameter int unsigned PROG_CYCLES  = 16,
   parameter int unsigned ERASE_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_prog,
   input  logic start_erase,
   output logic busy,
   output opk_t op_kind,
   output logic op_start
);

   localparam int unsigned LONGEST = larger_of(PROG_CYCLES, ERASE_CYCLES);
   localparam int unsigned CW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;

   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("pollst_timer: PROG_CYCLES must be at least 1");
   end
   if (ERASE_CYCLES < 1) begin : g_bad_erase
      $error("pollst_timer: ERASE_CYCLES must be at least 1");
   end

   logic          busy_q;
   logic [CW-1:0] remain_q;
   opk_t          kind_q;
   logic          take_erase;
   logic          take_prog;

   // erase has priority when both requests arrive together
   always_comb begin
      take_erase = !busy_q && start_erase;
      take_prog  = !busy_q && start_prog && !start_erase;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         remain_q <= '0;
         kind_q   <= OPK_IDLE;
      end else if (take_erase) begin
         busy_q   <= 1'b1;
         remain_q <= CW'(ERASE_CYCLES - 1);
         kind_q   <= OPK_ERASE;
      end else if (take_prog) begin
         busy_q   <= 1'b1;
         remain_q <= CW'(PROG_CYCLES - 1);
         kind_q   <= OPK_PROG;
      end else if (busy_q) begin
         if (remain_q == '0) begin
            busy_q <= 1'b0;
            kind_q <= OPK_IDLE;
         end else begin
            remain_q <= remain_q - 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign op_kind  = kind_q;
   assign op_start = take_erase || take_prog;

endmodule

// File: rtl/pollst_hold.sv
module pollst_hold #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   if (DW < 1) begin : g_bad_dw
      $error("pollst_hold: DW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (capture) begin
         q <= d;
      end
   end

endmodule

// File: rtl/pollst_rdmux.sv
module pollst_rdmux
   import pollst_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned FLAG_BIT = 7,
   parameter int unsigned TOG_BIT  = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          busy,
   input  opk_t          op_kind,
   input  logic          op_start,
   input  logic [DW-1:0] held,
   input  logic [DW-1:0] array_data,
   output logic [DW-1:0] rd_data
);

   logic          toggle_q;
   logic [DW-1:0] composed;
   logic [DW-1:0] rd_q;

   // toggle flop: cleared at each new operation, flips on each busy read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         toggle_q <= 1'b0;
      end else if (op_start) begin
         toggle_q <= 1'b0;
      end else if (rd_en && busy) begin
         toggle_q <= ~toggle_q;
      end
   end

   for (genvar g = 0; g < DW; g++) begin : g_bit
      if (g == FLAG_BIT) begin : g_flag
         assign composed[g] = busy ? ((op_kind == OPK_PROG) ? ~held[g] : 1'b0)
                                   : array_data[g];
      end else if (g == TOG_BIT) begin : g_tog
         assign composed[g] = busy ? toggle_q : array_data[g];
      end else begin : g_pass
         assign composed[g] = array_data[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= composed;
      end
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/pollst_unit.sv
module pollst_unit
   import pollst_pkg::*;
#(
   parameter int unsigned DW           = 8,
   parameter int unsigned FLAG_BIT     = 7,
   parameter int unsigned TOG_BIT      = 6,
   parameter int unsigned PROG_CYCLES  = 16,
   parameter int unsigned ERASE_CYCLES = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_prog,
   input  logic          start_erase,
   input  logic [DW-1:0] load_data,
   input  logic          rd_en,
   input  logic [DW-1:0] array_data,
   output logic [DW-1:0] rd_data,
   output logic          busy
);

   if (FLAG_BIT >= DW) begin : g_bad_flag
      $error("pollst_unit: FLAG_BIT outside data width");
   end
   if (TOG_BIT >= DW) begin : g_bad_tog
      $error("pollst_unit: TOG_BIT outside data width");
   end
   if (FLAG_BIT == TOG_BIT) begin : g_same_bits
      $error("pollst_unit: FLAG_BIT and TOG_BIT must differ");
   end

   opk_t          op_kind;
   logic          op_start;
   logic          take_load;
   logic [DW-1:0] held_q;

   pollst_timer #(
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_CYCLES(ERASE_CYCLES)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_prog (start_prog),
      .start_erase(start_erase),
      .busy       (busy),
      .op_kind    (op_kind),
      .op_start   (op_start)
   );

   assign take_load = !busy && start_prog && !start_erase;

   pollst_hold #(
      .DW(DW)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(take_load),
      .d      (load_data),
      .q      (held_q)
   );

   pollst_rdmux #(
      .DW      (DW),
      .FLAG_BIT(FLAG_BIT),
      .TOG_BIT (TOG_BIT)
   ) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .busy      (busy),
      .op_kind   (op_kind),
      .op_start  (op_start),
      .held      (held_q),
      .array_data(array_data),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/pollst_unit_chk.sv
module pollst_unit_chk
   import pollst_pkg::*;
#(
   parameter int unsigned DW           = 8,
   parameter int unsigned FLAG_BIT     = 7,
   parameter int unsigned TOG_BIT      = 6,
   parameter int unsigned PROG_CYCLES  = 16,
   parameter int unsigned ERASE_CYCLES = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_prog,
   input logic          start_erase,
   input logic          rd_en,
   input logic [DW-1:0] array_data,
   input logic [DW-1:0] rd_data,
   input logic          busy,
   input opk_t          op_kind,
   input logic [DW-1:0] held
);

   localparam int unsigned LONGEST = larger_of(PROG_CYCLES, ERASE_CYCLES);

   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else busy_len <= 0;
   end

   // R1 and R9: reset forces idle and clears the read data
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (!busy && rd_data == '0);
      end
   end

   assert_rise_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_prog || start_erase));

   assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_len <= LONGEST);

   assert_busy_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (start_prog || start_erase)) |=> $stable(held));

   assert_prog_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && op_kind == OPK_PROG) |=> rd_data[FLAG_BIT] == ~$past(held[FLAG_BIT]));

   assert_erase_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && op_kind == OPK_ERASE) |=> rd_data[FLAG_BIT] == 1'b0);

   assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && $past(rd_en && busy)) |=> rd_data[TOG_BIT] != $past(rd_data[TOG_BIT]));

   assert_idle_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !busy) |=> rd_data == $past(array_data));

   assert_hold_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

bind pollst_unit pollst_unit_chk #(
   .DW          (DW),
   .FLAG_BIT    (FLAG_BIT),
   .TOG_BIT     (TOG_BIT),
   .PROG_CYCLES (PROG_CYCLES),
   .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_prog (start_prog),
   .start_erase(start_erase),
   .rd_en      (rd_en),
   .array_data (array_data),
   .rd_data    (rd_data),
   .busy       (busy),
   .op_kind    (op_kind),
   .held       (held_q)
);

// File: tb/pollst_unit_bench.sv
module pollst_unit_bench;

   localparam int DW = 8;
   localparam int PC = 16;
   localparam int EC = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_prog = 1'b0;
   logic          start_erase = 1'b0;
   logic [DW-1:0] load_data = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] array_data = '0;
   logic [DW-1:0] rd_data;
   logic          busy;

   always #2 clk = ~clk;

   pollst_unit #(
      .DW(DW), .FLAG_BIT(7), .TOG_BIT(6), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
   ) u_pollst_unit (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
      .load_data(load_data), .rd_en(rd_en), .array_data(array_data),
      .rd_data(rd_data), .busy(busy)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } item_t;

   item_t sb[$];
   item_t cur;
   logic  mon_armed = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: a read sampled at posedge shows up by the following negedge
   always @(posedge clk) mon_armed <= rd_en;

   always @(negedge clk) begin
      if (mon_armed) begin
         if (sb.size() == 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10 actual=unexpected read expected=none");
         end else begin
            cur = sb.pop_front();
            chk(cur.tag, 32'(rd_data), 32'(cur.exp));
         end
      end
   end

   function automatic logic [DW-1:0] bexp(input logic [DW-1:0] arr, input logic b7, input logic b6);
      return {b7, b6, arr[5:0]};
   endfunction

   task automatic rd(input logic [DW-1:0] arr, input logic [DW-1:0] exp, input string tag);
      rd_en = 1'b1;
      array_data = arr;
      sb.push_back('{exp, tag});
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic start_op(input logic p, input logic e, input logic [DW-1:0] ld);
      start_prog = p;
      start_erase = e;
      load_data = ld;
      @(negedge clk);
      start_prog = 1'b0;
      start_erase = 1'b0;
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy === 1'b1 && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<=50000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 32'(busy), 0);
      chk("R1 rd_data in reset", 32'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // idle reads and hold
      rd(8'h5A, 8'h5A, "R8 idle read");
      @(negedge clk);
      array_data = 8'h11;
      repeat (2) @(negedge clk);
      chk("R10 hold without read", 32'(rd_data), 32'h5A);

      // program length
      start_op(1'b1, 1'b0, 8'h3C);
      count_busy(n);
      chk("R2 program length", n, PC);

      // program with back-to-back and spaced reads
      start_op(1'b1, 1'b0, 8'h3C);
      rd(8'hFF, bexp(8'hFF, 1'b1, 1'b0), "R5 R7 read1");
      rd(8'hFF, bexp(8'hFF, 1'b1, 1'b1), "R5 R7 read2");
      rd(8'h00, bexp(8'h00, 1'b1, 1'b0), "R7 R8 read3");
      @(negedge clk);
      rd(8'h81, bexp(8'h81, 1'b1, 1'b1), "R7 spaced read");
      count_busy(n);
      chk("R2 program remainder", n, PC - 5);
      rd(8'h5A, 8'h5A, "R8 idle after program");
      rd(8'h5A, 8'h5A, "R8 toggle stopped");

      // starts while busy are ignored
      start_op(1'b1, 1'b0, 8'hA5);
      rd(8'h0F, bexp(8'h0F, 1'b0, 1'b0), "R5 flag inverse of A5");
      start_op(1'b1, 1'b0, 8'h00);
      rd(8'h0F, bexp(8'h0F, 1'b0, 1'b1), "R4 reload ignored");
      start_op(1'b0, 1'b1, 8'h00);
      rd(8'h0F, bexp(8'h0F, 1'b0, 1'b0), "R4 erase ignored");
      count_busy(n);
      chk("R4 busy length unchanged", n, PC - 5);

      // erase wins over program; toggle cleared after odd read count
      start_op(1'b1, 1'b1, 8'h00);
      rd(8'hFF, bexp(8'hFF, 1'b0, 1'b0), "R3 R6 R7 erase read1");
      rd(8'hFF, bexp(8'hFF, 1'b0, 1'b1), "R6 R7 erase read2");
      count_busy(n);
      chk("R3 erase length", n, EC - 2);

      // reset aborts an operation
      start_op(1'b1, 1'b0, 8'h7F);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9 busy dropped by reset", 32'(busy), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h33, 8'h33, "R9 read after abort");
      start_op(1'b1, 1'b0, 8'h00);
      count_busy(n);
      chk("R9 full rerun length", n, PC);

      @(negedge clk);
      chk("R10 scoreboard drained", sb.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule